// File: doc/BRIEF.md
# DAC Input Word Selector with Synchronous Blanking

This block is the digital front end of a high-speed 8-bit digital-to-analog converter. Two data words arrive on separate buses, and a select line picks which one reaches the converter on each conversion-clock period. If the select line is held high, word A runs at the full rate. If the select line toggles every period, the two half-rate streams are interleaved into one full-rate stream.

A blanking request forces the whole code, and a separate blank bit, to the all-ones level. The request is only looked at while word A is selected. On the clock edge where the select line is first seen low, the request level is captured. That captured level is then held for as long as word B stays selected. As a result, a blank captured high while the select line stays low is never cleared. The data bits are in complemented form, and the block carries them through bit for bit without inverting them. All outputs are registered on the falling edge of the conversion clock.

Top module: `dac_front_mux`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling clock edge, drives `code_q` to all zeros and `blank_q` to 0. It also clears the captured blank state and the remembered select level, so that a low select after reset does not count as a select fall.
- R2: On a falling edge where `sel_a` is 1 and `blank_req` is 0, the next `code_q` equals `word_a` and `blank_q` becomes 0.
- R3: On a falling edge where `sel_a` is 0 and the effective blank is 0, the next `code_q` equals `word_b` and `blank_q` becomes 0.
- R4: On a falling edge where `sel_a` is 1 and `blank_req` is 1, the next `code_q` is all ones and `blank_q` becomes 1.
- R5: On a falling edge where `sel_a` is 0 and `sel_a` was also 0 at the previous edge, `blank_req` is ignored. The effective blank keeps the value it had at the previous edge.
- R6: On the first falling edge where `sel_a` is 0 after an edge with `sel_a` at 1, the current `blank_req` is captured. It applies to that same edge's output and is held afterwards.
- R7: A captured blank of 1 keeps `code_q` at all ones and `blank_q` at 1 for as long as `sel_a` stays 0, whatever `blank_req` does. The first edge with `sel_a` at 1 and `blank_req` at 0 releases it.
- R8: The data bits are not inverted. Each bit of `code_q` equals the same bit of the selected word, so input 8'h01 yields 8'h01 and 8'h80 yields 8'h80.
- R9: Outputs change only on falling clock edges. A change on any input between falling edges leaves `code_q` and `blank_q` unchanged until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | 1 selects word A, 0 selects word B |
| blank_req | input | 1 | Blanking request, active high |
| word_a | input | 8 | Data word A, complemented coding |
| word_b | input | 8 | Data word B, complemented coding |
| code_q | output | 8 | Registered code to the segment logic |
| blank_q | output | 1 | Registered blank bit |

## Verification
Capturing a blank and switching words can land on the same edge. When `sel_a` falls while `blank_req` is high, the edge must both switch to word B and lock blanking on. When `sel_a` rises with `blank_req` low, the edge must both release blanking and return to word A. The table and the lock-up test set up exactly these coincidences. A per-cycle model runs alongside, with a toggling select and a pseudo-random blank request, and is compared with both outputs after every falling edge. Every output is also checked just before each falling edge, to catch any change between edges.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   localparam int unsigned DACFE_W_DEF = 8;

   typedef enum logic {
      PICK_B = 1'b0,
      PICK_A = 1'b1
   } pick_e;

   // Effective blank: the live request while A is selected or on the select-fall edge,
   // otherwise the captured value.
   function automatic logic blank_pick(input logic sel_now, input logic sel_prev,
                                       input logic req, input logic held);
      return (sel_now || sel_prev) ? req : held;
   endfunction

endpackage

// File: rtl/dacfe_blank_hold.sv
module dacfe_blank_hold
   import dacfe_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sel_a,
   input  logic blank_req,
   output logic blank_eff
);

   logic sel_seen;
   logic blank_held;

   always_comb begin
      blank_eff = blank_pick(sel_a, sel_seen, blank_req, blank_held);
   end

   always_ff @(negedge clk) begin
      if (rst) begin
         sel_seen   <= 1'b0;
         blank_held <= 1'b0;
      end else begin
         sel_seen   <= sel_a;
         blank_held <= blank_eff;
      end
   end

endmodule

// File: rtl/dacfe_word_pick.sv
module dacfe_word_pick
   import dacfe_pkg::*;
#(
   parameter int unsigned W = DACFE_W_DEF
) (
   input  logic         sel_a,
   input  logic         blank_eff,
   input  logic [W-1:0] word_a,
   input  logic [W-1:0] word_b,
   output logic [W-1:0] code_d
);

   pick_e pick;

   always_comb begin
      pick = sel_a ? PICK_A : PICK_B;
   end

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      always_comb begin
         if (blank_eff)
            code_d[gi] = 1'b1;
         else if (pick == PICK_A)
            code_d[gi] = word_a[gi];
         else
            code_d[gi] = word_b[gi];
      end
   end

endmodule

// File: rtl/dacfe_out_stage.sv
module dacfe_out_stage
   import dacfe_pkg::*;
#(
   parameter int unsigned W = DACFE_W_DEF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] code_d,
   input  logic         blank_d,
   output logic [W-1:0] code_q,
   output logic         blank_q
);

   always_ff @(negedge clk) begin
      if (rst) begin
         code_q  <= '0;
         blank_q <= 1'b0;
      end else begin
         code_q  <= code_d;
         blank_q <= blank_d;
      end
   end

endmodule

// File: rtl/dac_front_mux.sv
module dac_front_mux
   import dacfe_pkg::*;
#(
   parameter int unsigned DATA_W = DACFE_W_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_a,
   input  logic              blank_req,
   input  logic [DATA_W-1:0] word_a,
   input  logic [DATA_W-1:0] word_b,
   output logic [DATA_W-1:0] code_q,
   output logic              blank_q
);

   localparam int unsigned CODE_MSB = DATA_W - 1;

   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("dac_front_mux: DATA_W must lie in 2..16");
   end

   logic              blank_eff;
   logic [CODE_MSB:0] code_d;

   dacfe_blank_hold u_hold (
      .clk       (clk),
      .rst       (rst),
      .sel_a     (sel_a),
      .blank_req (blank_req),
      .blank_eff (blank_eff)
   );

   dacfe_word_pick #(.W(DATA_W)) u_pick (
      .sel_a     (sel_a),
      .blank_eff (blank_eff),
      .word_a    (word_a),
      .word_b    (word_b),
      .code_d    (code_d)
   );

   dacfe_out_stage #(.W(DATA_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .code_d  (code_d),
      .blank_d (blank_eff),
      .code_q  (code_q),
      .blank_q (blank_q)
   );

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         sel_a,
   input logic         blank_req,
   input logic [W-1:0] word_a,
   input logic [W-1:0] word_b,
   input logic [W-1:0] code_q,
   input logic         blank_q
);

   assert_reset_clear_R1: assert property (@(negedge clk)
      rst |=> (code_q == '0 && !blank_q));

   assert_word_a_pass_R2: assert property (@(negedge clk) disable iff (rst)
      (sel_a && !blank_req) |=> (!blank_q && code_q == $past(word_a)));

   assert_word_b_pass_R3: assert property (@(negedge clk) disable iff (rst)
      !sel_a |=> (blank_q || code_q == $past(word_b)));

   assert_blank_force_R4: assert property (@(negedge clk) disable iff (rst)
      (sel_a && blank_req) |=> (blank_q && (&code_q)));

   assert_blank_frozen_R5: assert property (@(negedge clk) disable iff (rst)
      (!sel_a && !$past(sel_a) && !$past(rst)) |=> (blank_q == $past(blank_q)));

   assert_fall_capture_R6: assert property (@(negedge clk) disable iff (rst)
      (!sel_a && $past(sel_a) && !$past(rst)) |=> (blank_q == $past(blank_req)));

   assert_lockup_hold_R7: assert property (@(negedge clk) disable iff (rst)
      (!sel_a && !$past(sel_a) && blank_q) |=> (blank_q && (&code_q)));

   assert_blank_consistent_R4: assert property (@(negedge clk) disable iff (rst)
      blank_q |-> (&code_q));

endmodule

bind dac_front_mux dacfe_chk #(.W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sel_a     (sel_a),
   .blank_req (blank_req),
   .word_a    (word_a),
   .word_b    (word_b),
   .code_q    (code_q),
   .blank_q   (blank_q)
);

// File: tb/test_dac_front_mux.sv
module test_dac_front_mux;

   logic       clk = 1'b0;
   logic       rst;
   logic       sel_a;
   logic       blank_req;
   logic [7:0] word_a;
   logic [7:0] word_b;
   logic [7:0] code_q;
   logic       blank_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic m_prev = 1'b0;
   logic m_hold = 1'b0;
   logic [7:0] last_code = 8'h00;
   logic       last_blank = 1'b0;

   always #10 clk = ~clk;

   dac_front_mux i_dac_front_mux (
      .clk(clk), .rst(rst), .sel_a(sel_a), .blank_req(blank_req),
      .word_a(word_a), .word_b(word_b), .code_q(code_q), .blank_q(blank_q)
   );

   // row: {sel, blank, a[8], b[8], exp_blank, exp_code[8]}
   localparam int NROW = 13;
   localparam logic [26:0] VEC [NROW] = '{
      {1'b1, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'h3C},  // R2 word A
      {1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'hA5},  // R3 R6 fall, blank low
      {1'b1, 1'b1, 8'h12, 8'h34, 1'b1, 8'hFF},  // R4 blank on A
      {1'b0, 1'b0, 8'h12, 8'h34, 1'b0, 8'h34},  // R6 fall captures low
      {1'b0, 1'b1, 8'h56, 8'h78, 1'b0, 8'h78},  // R5 request ignored on B
      {1'b1, 1'b0, 8'h9A, 8'hBC, 1'b0, 8'h9A},  // R2
      {1'b0, 1'b1, 8'h9A, 8'hBC, 1'b1, 8'hFF},  // R6 fall captures high
      {1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 8'hFF},  // R5 R7 held
      {1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 8'h11},  // R7 release
      {1'b1, 1'b1, 8'h00, 8'hFF, 1'b1, 8'hFF},  // R4
      {1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00},  // R2
      {1'b0, 1'b0, 8'h80, 8'h01, 1'b0, 8'h01},  // R8 no inversion
      {1'b0, 1'b0, 8'h7F, 8'hFE, 1'b0, 8'hFE}   // R3 R8
   };

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got blank=%b code=%h, expected blank=%b code=%h",
                  req, act[8], act[7:0], exp[8], exp[7:0]);
      end
   endtask

   // one conversion period: drive after rising edge, verify stability (R9), check after falling edge
   task automatic cycle(input logic s, input logic b, input logic [7:0] a, input logic [7:0] bw,
                        input logic [8:0] exp, input string req);
      logic eff;
      @(posedge clk);
      #1;
      sel_a = s; blank_req = b; word_a = a; word_b = bw; rst = 1'b0;
      #2;
      check("R9 stable between edges", {blank_q, code_q}, {last_blank, last_code});
      eff = (s || m_prev) ? b : m_hold;
      m_hold = eff;
      m_prev = s;
      @(negedge clk);
      #1;
      check(req, {blank_q, code_q}, exp);
      last_blank = exp[8];
      last_code  = exp[7:0];
   endtask

   function automatic logic [8:0] model_exp(input logic s, input logic b,
                                            input logic [7:0] a, input logic [7:0] bw);
      logic eff;
      eff = (s || m_prev) ? b : m_hold;
      return eff ? 9'h1FF : {1'b0, (s ? a : bw)};
   endfunction

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      @(negedge clk);
      #1;
      check("R1 reset state", {blank_q, code_q}, 9'h000);
      m_prev = 1'b0; m_hold = 1'b0;
      last_blank = 1'b0; last_code = 8'h00;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      logic s, b;
      logic [7:0] a, bw;
      rst = 1'b1; sel_a = 1'b0; blank_req = 1'b0; word_a = '0; word_b = '0;
      do_reset();

      // R1: low select straight after reset is not a fall, blank request ignored
      cycle(1'b0, 1'b1, 8'h44, 8'h5A, 9'h05A, "R1 no fall after reset");

      do_reset();
      for (int i = 0; i < NROW; i++) begin
         cycle(VEC[i][26], VEC[i][25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:0],
               $sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8)", i));
      end

      // R7 lock-up: capture high on the fall, then keep select low with a quiet request
      cycle(1'b1, 1'b0, 8'h20, 8'h30, 9'h020, "R2 before lock-up");
      cycle(1'b0, 1'b1, 8'h20, 8'h30, 9'h1FF, "R6 lock-up capture");
      for (int k = 0; k < 24; k++) begin
         cycle(1'b0, k[0], 8'h20 + 8'(k), 8'h30 + 8'(k), 9'h1FF, "R7 lock-up persists");
      end
      // R1 reset clears the lock
      do_reset();
      cycle(1'b0, 1'b0, 8'h66, 8'h77, 9'h077, "R1 hold cleared by reset");
      // lock again, release via select high
      cycle(1'b1, 1'b0, 8'h01, 8'h02, 9'h001, "R8 low bit passes");
      cycle(1'b0, 1'b1, 8'h01, 8'h02, 9'h1FF, "R6 capture again");
      cycle(1'b1, 1'b0, 8'hC3, 8'h02, 9'h0C3, "R7 release on select high");

      // interleaved operation against the per-cycle model
      lf = 32'h1ACE_B00C;
      s = 1'b1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         s  = (lf[7:0] == 8'h00) ? s : ~s;
         b  = (lf[11:9] == 3'b000);
         a  = lf[19:12];
         bw = lf[27:20];
         cycle(s, b, a, bw, model_exp(s, b, a, bw), "R2 R3 R4 R5 R6 interleaved");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule